// File: doc/BRIEF.md
# One-Time-Programmable Fuse Program and Verify Sequencer

This block is the digital control for a one-time-programmable fuse memory. The memory is organised as a chain of 64-bit blocks, and the blocks together act as one long serial shift register. The fuse cells, the high-voltage supply and the sense amplifiers are outside the block. Write data is shifted into the per-bit data registers. While the program request is held high, each program step moves a bit pointer forward by one position. The step raises a one-cycle burn strobe on that bit, but only if the bit's data register holds 1. Bits holding 0 are passed over with no strobe.

A verify pass compares the data registers with the sensed fuse contents, which arrive as a parallel vector. Each data bit is overwritten with its own failure status: 1 where a programmed bit did not read back as 1, and 0 everywhere else. A following program pass therefore only strobes the bits that failed. The program-done output has two uses. It marks the step of the final bit. It also rises at once when the data registers hold no 1 at all, so it serves as the pass flag after a verify.

The control is a four-state machine:
- IDLE allows shifting and accepts the requests.
- ARMED walks the bits.
- DONE holds the done flag.
- VERIFY is the one-cycle compare.

The transitions are:
- IDLE to ARMED on a program request with nonzero data.
- IDLE to DONE on a program request with all-zero data.
- IDLE to VERIFY on a verify request.
- ARMED to DONE on the step that handles the last bit.
- ARMED or DONE back to IDLE when the request drops.
- VERIFY back to IDLE after one cycle.

Top module: `otp_prog_seq`

## Requirements
- R1: After reset, prog_done, burn_vec and mismatch_err are 0, and all data registers are 0, so ser_out reads 0.
- R2: In IDLE, with no program or verify request, each clock with shift_en high moves ser_in into the highest bit and every bit one position toward bit 0. ser_out always shows bit 0, so the first bit of N shifted in ends in bit 0.
- R3: In ARMED, a clock with prog_step high and a 1 in the data register at the pointer drives burn_vec to a one-hot value at that bit for exactly the next cycle. The pointer starts at bit 0 and rises by one on each step.
- R4: A step on a bit whose data register holds 0 drives burn_vec to 0, and the pointer still advances.
- R5: prog_done rises in the same cycle as the strobe result of the step on the last bit. It stays high while prog_req is high, and no strobe follows it.
- R6: When prog_req is sampled high in IDLE and every data register is 0, prog_done is high from the next cycle and no strobe is ever issued.
- R7: One cycle after prog_req is sampled low, prog_done is 0 and the pointer is back at bit 0.
- R8: A verify_go sampled in IDLE enters VERIFY. At the end of that cycle, each data bit becomes data AND NOT sense_data, taken from sense_data in that cycle. Only failed 1-bits are strobed in the next program pass.
- R9: The same verify sets mismatch_err to 1 if any bit holds data 0 and sensed 1, and to 0 otherwise. Such bits are not marked for reprogramming.
- R10: shift_en and verify_go have no effect on the data registers while prog_req is high.
- R11: prog_step has no effect while prog_req is low, and burn_vec stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| shift_en | input | 1 | Shift the chain by one bit |
| ser_in | input | 1 | Serial data into the highest bit |
| ser_out | output | 1 | Serial data out of bit 0 |
| prog_req | input | 1 | Program request, held high for a pass |
| prog_step | input | 1 | One program step per sampled high |
| burn_vec | output | NUM_BLOCKS*64 | One-hot per-bit burn strobe |
| prog_done | output | 1 | Last bit reached, or nothing left to program |
| verify_go | input | 1 | Start a verify compare |
| sense_data | input | NUM_BLOCKS*64 | Sensed fuse contents, held during VERIFY |
| mismatch_err | output | 1 | Last verify found an unexpected blown bit |

## Verification
The bench drives inputs just after a rising edge and samples outputs just before the next one.

The results are due at these points:
- A step's strobe is visible in the cycle directly after the edge that sampled the step, so each step is checked one cycle later.
- prog_done rises one cycle after the request when the data is all zero, and together with the last strobe otherwise.
- prog_done falls one cycle after the request drops.
- A verify updates the data and the error flag two edges after verify_go is driven: one edge to enter VERIFY and one to compare.
- ser_out is read combinationally before each shift.

The model's expected vectors come from the loaded pattern and the sensed pattern alone.

// File: rtl/otp_seq_pkg.sv
package otp_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARMED  = 2'd1,
        ST_DONE   = 2'd2,
        ST_VERIFY = 2'd3
    } seq_state_e;
endpackage

// File: rtl/otp_fuse_chain.sv
module otp_fuse_chain #(
    parameter int NUM_BLOCKS = 2,
    parameter int BLK_BITS   = 64,
    localparam int TOTAL     = NUM_BLOCKS * BLK_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             do_shift,
    input  logic             ser_in,
    input  logic             do_verify,
    input  logic [TOTAL-1:0] sense,
    output logic [TOTAL-1:0] data,
    output logic             ser_out,
    output logic             mismatch
);
    logic [NUM_BLOCKS-1:0] link;

    for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
        if (b == NUM_BLOCKS - 1) begin : g_head
            assign link[b] = ser_in;
        end else begin : g_mid
            assign link[b] = data[(b + 1) * BLK_BITS];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                data[b*BLK_BITS +: BLK_BITS] <= '0;
            end else if (do_verify) begin
                // keep only the ones that did not read back
                data[b*BLK_BITS +: BLK_BITS] <= data[b*BLK_BITS +: BLK_BITS]
                                              & ~sense[b*BLK_BITS +: BLK_BITS];
            end else if (do_shift) begin
                data[b*BLK_BITS +: BLK_BITS] <= {link[b], data[b*BLK_BITS+1 +: BLK_BITS-1]};
            end
        end
    end

    assign ser_out = data[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mismatch <= 1'b0;
        end else if (do_verify) begin
            mismatch <= |(~data & sense);
        end
    end
endmodule

// File: rtl/otp_bit_pointer.sv
module otp_bit_pointer #(
    parameter int TOTAL  = 128,
    localparam int PTR_W = $clog2(TOTAL)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ptr_clr,
    input  logic             fire,
    input  logic [TOTAL-1:0] data,
    output logic             ptr_last,
    output logic [TOTAL-1:0] burn_q
);
    logic [PTR_W-1:0] ptr;
    logic             cur_bit;

    assign cur_bit  = data[ptr];
    assign ptr_last = (ptr == PTR_W'(TOTAL - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (ptr_clr) begin
            ptr <= '0;
        end else if (fire && !ptr_last) begin
            ptr <= ptr + 1'b1;
        end
    end

    for (genvar i = 0; i < TOTAL; i++) begin : g_strobe
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                burn_q[i] <= 1'b0;
            end else begin
                burn_q[i] <= fire && cur_bit && (ptr == PTR_W'(i));
            end
        end
    end
endmodule

// File: rtl/otp_seq_fsm.sv
module otp_seq_fsm
    import otp_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic prog_req,
    input  logic prog_step,
    input  logic verify_go,
    input  logic shift_en,
    input  logic data_zero,
    input  logic ptr_last,
    output logic ptr_clr,
    output logic fire,
    output logic do_shift,
    output logic do_verify,
    output logic done
);
    seq_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx  = state;
        ptr_clr   = 1'b0;
        fire      = 1'b0;
        do_shift  = 1'b0;
        do_verify = 1'b0;
        done      = 1'b0;
        unique case (state)
            ST_IDLE: begin
                ptr_clr = 1'b1;
                if (prog_req)       state_nx = data_zero ? ST_DONE : ST_ARMED;
                else if (verify_go) state_nx = ST_VERIFY;
                else                do_shift = shift_en;
            end
            ST_ARMED: begin
                if (!prog_req) begin
                    ptr_clr  = 1'b1;
                    state_nx = ST_IDLE;
                end else if (prog_step) begin
                    fire = 1'b1;
                    if (ptr_last) state_nx = ST_DONE;
                end
            end
            ST_DONE: begin
                done = 1'b1;
                if (!prog_req) begin
                    ptr_clr  = 1'b1;
                    state_nx = ST_IDLE;
                end
            end
            ST_VERIFY: begin
                do_verify = 1'b1;
                state_nx  = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/otp_prog_seq.sv
module otp_prog_seq #(
    parameter int NUM_BLOCKS = 2,
    localparam int BLK_BITS  = 64,
    localparam int TOTAL     = NUM_BLOCKS * BLK_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             ser_in,
    output logic             ser_out,
    input  logic             prog_req,
    input  logic             prog_step,
    output logic [TOTAL-1:0] burn_vec,
    output logic             prog_done,
    input  logic             verify_go,
    input  logic [TOTAL-1:0] sense_data,
    output logic             mismatch_err
);
    logic [TOTAL-1:0] data;
    logic ptr_clr, fire, do_shift, do_verify, ptr_last;

    otp_seq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .prog_req(prog_req), .prog_step(prog_step),
        .verify_go(verify_go), .shift_en(shift_en), .data_zero(data == '0),
        .ptr_last(ptr_last), .ptr_clr(ptr_clr), .fire(fire),
        .do_shift(do_shift), .do_verify(do_verify), .done(prog_done)
    );

    otp_fuse_chain #(.NUM_BLOCKS(NUM_BLOCKS), .BLK_BITS(BLK_BITS)) u_chain (
        .clk(clk), .rst_n(rst_n), .do_shift(do_shift), .ser_in(ser_in),
        .do_verify(do_verify), .sense(sense_data), .data(data),
        .ser_out(ser_out), .mismatch(mismatch_err)
    );

    otp_bit_pointer #(.TOTAL(TOTAL)) u_ptr (
        .clk(clk), .rst_n(rst_n), .ptr_clr(ptr_clr), .fire(fire),
        .data(data), .ptr_last(ptr_last), .burn_q(burn_vec)
    );
endmodule

// File: rtl/otp_prog_seq_chk.sv
module otp_prog_seq_chk #(
    parameter int TOTAL = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             prog_req,
    input logic [TOTAL-1:0] burn_vec,
    input logic             prog_done
);
    AST_BURN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(burn_vec)); // R3
    AST_BURN_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (burn_vec != '0) |=> ((burn_vec & $past(burn_vec)) == '0)); // R3
    AST_DONE_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_req |=> !prog_done); // R7
    AST_NO_BURN_UNREQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_req |=> (burn_vec == '0)); // R11
    AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_done && $past(prog_done)) |-> (burn_vec == '0)); // R5
endmodule

bind otp_prog_seq otp_prog_seq_chk #(.TOTAL(TOTAL)) u_chk (
    .clk(clk), .rst_n(rst_n), .prog_req(prog_req),
    .burn_vec(burn_vec), .prog_done(prog_done)
);

// File: tb/otp_prog_seq_bench.sv
module otp_prog_seq_bench;
    localparam int NB = 2;
    localparam int N  = NB * 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic shift_en = 1'b0, ser_in = 1'b0, ser_out;
    logic prog_req = 1'b0, prog_step = 1'b0, prog_done;
    logic verify_go = 1'b0, mismatch_err;
    logic [N-1:0] burn_vec, sense_data = '0;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    otp_prog_seq #(.NUM_BLOCKS(NB)) u_otp_prog_seq (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .ser_in(ser_in),
        .ser_out(ser_out), .prog_req(prog_req), .prog_step(prog_step),
        .burn_vec(burn_vec), .prog_done(prog_done), .verify_go(verify_go),
        .sense_data(sense_data), .mismatch_err(mismatch_err)
    );

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic load(input logic [N-1:0] v);
        for (int i = 0; i < N; i++) begin
            shift_en = 1'b1;
            ser_in   = v[i];
            tick();
        end
        shift_en = 1'b0;
        ser_in   = 1'b0;
    endtask

    // destructive read: bit i appears on ser_out before shift i (R2)
    task automatic readback(input string req, input logic [N-1:0] exp);
        logic [N-1:0] got;
        for (int i = 0; i < N; i++) begin
            got[i]   = ser_out;
            shift_en = 1'b1;
            tick();
        end
        shift_en = 1'b0;
        chk(req, got, exp);
    endtask

    // full program pass over a loaded pattern: R3, R4, R5, R7
    task automatic program_pass(input logic [N-1:0] pat);
        logic [N-1:0] onehot;
        prog_req = 1'b1;
        tick();
        if (pat == '0) begin
            chk("R6 done", N'(prog_done), N'(1));
        end else begin
            for (int i = 0; i < N; i++) begin
                prog_step = 1'b1;
                tick();
                onehot = '0;
                onehot[i] = 1'b1;
                chk(pat[i] ? "R3 burn" : "R4 skip", burn_vec, pat[i] ? onehot : '0);
                chk("R5 done", N'(prog_done), N'(i == N - 1));
            end
            prog_step = 1'b0;
        end
        for (int i = 0; i < 3; i++) begin
            prog_step = 1'b1;
            tick();
            chk("R5 hold", N'(prog_done), N'(1));
            chk("R5 quiet", burn_vec, '0);
        end
        prog_step = 1'b0;
        prog_req  = 1'b0;
        tick();
        chk("R7 done low", N'(prog_done), N'(0));
    endtask

    task automatic do_verify(input logic [N-1:0] sense);
        sense_data = sense;
        verify_go  = 1'b1;
        tick();
        verify_go = 1'b0;
        tick();
    endtask

    task automatic t_reset();
        chk("R1 done", N'(prog_done), N'(0));
        chk("R1 burn", burn_vec, '0);
        chk("R1 err", N'(mismatch_err), N'(0));
        chk("R1 ser_out", N'(ser_out), N'(0));
    endtask

    task automatic t_shift();
        logic [N-1:0] p = {32'hDEADBEEF, 32'h0F0F1234, 32'h80000001, 32'hA5A5C3C3};
        load(p);
        readback("R2 readback", p);
        load('1);
        readback("R2 all ones", '1);
    endtask

    task automatic t_program_and_restart();
        logic [N-1:0] p = {32'h80000000, 32'h00010000, 32'h00000100, 32'h00000005};
        load(p);
        program_pass(p);
        // new pass must start at bit 0 again (R7)
        prog_req = 1'b1;
        tick();
        prog_step = 1'b1;
        tick();
        chk("R7 restart at bit0", burn_vec, N'(1));
        prog_step = 1'b0;
        prog_req  = 1'b0;
        tick();
        readback("R3 data kept", p);
    endtask

    task automatic t_verify_fail();
        logic [N-1:0] p     = {32'hF000000F, 32'h00FF0000, 32'h12345678, 32'h0000FFFF};
        logic [N-1:0] sense = (p & ~{32'h10000001, 32'h00010000, 32'h00000008, 32'h00008001})
                              | {32'h0, 32'h0, 32'h0, 32'h00010000};
        load(p);
        do_verify(sense);
        chk("R9 mismatch set", N'(mismatch_err), N'(1));
        program_pass(p & ~sense);
        readback("R8 fail mask", p & ~sense);
    endtask

    task automatic t_verify_pass();
        logic [N-1:0] p = {32'h00C00000, 32'h0, 32'h00000003, 32'h70000000};
        load(p);
        do_verify(p);
        chk("R9 mismatch clear", N'(mismatch_err), N'(0));
        program_pass('0);
        readback("R8 passed data zero", '0);
    endtask

    task automatic t_ignore();
        logic [N-1:0] p = {32'h0000A000, 32'h0, 32'h0, 32'h00000006};
        load(p);
        // step without request (R11)
        for (int i = 0; i < 3; i++) begin
            prog_step = 1'b1;
            tick();
            chk("R11 no burn", burn_vec, '0);
        end
        prog_step = 1'b0;
        prog_req  = 1'b1;
        tick();
        shift_en = 1'b1;
        ser_in   = 1'b1;
        tick();
        tick();
        shift_en   = 1'b0;
        sense_data = '0;
        verify_go  = 1'b1;
        tick();
        tick();
        verify_go = 1'b0;
        prog_req  = 1'b0;
        tick();
        ser_in = 1'b0;
        readback("R10 data unchanged", p);
    endtask

    initial begin
        #10;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        tick();
        t_reset();
        t_shift();
        t_program_and_restart();
        t_verify_fail();
        t_verify_pass();
        t_ignore();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #400000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule